// File: doc/BRIEF.md
# Five-Stage Pipeline Interlock Controller

This block is the hazard control for an in-order pipeline whose stages run Fetch, Decode, ALU, LS1, LS2. Each cycle it compares the source register indices of the instruction in Decode with the destinations of the three older instructions it shadows in ALU, LS1 and LS2. From that comparison it picks a forwarding source for every operand. It also decides whether Fetch and Decode must hold while a no-op bubble enters ALU.

The result latency of a load depends on its width. A word load's data is usable once LS1 completes. A byte or halfword load's data is usable only once LS2 completes, because LS2 extends it. The block also handles two other cases. A branch taken in ALU flushes the two younger slots and redirects fetch. A multi-cycle ALU operation, such as a multiply or a shift by a register amount, declares its ALU cycle count when it issues, and the block then freezes Fetch, Decode and ALU until that count runs out.

The datapath, register bank and forwarding multiplexers are outside the block. It drives only the control outputs. The multi-cycle unit is a two-state machine. In `MC_IDLE`, an issuing instruction with a cycle count above one moves it to `MC_BUSY`. In `MC_BUSY`, it counts down and returns to `MC_IDLE` as its last hold cycle ends. Reset returns it to `MC_IDLE`.

Each cycle the block takes exactly one action:
- `ACT_BUSY`: the multi-cycle unit is busy.
- `ACT_FLUSH`: a branch is taken.
- `ACT_IDLE`: Decode holds no instruction.
- `ACT_STALL`: a load interlock is active.
- `ACT_ISSUE`: the instruction in Decode moves into ALU.

This list is also their priority order.

Top module: `ilk_ctrl`

## Requirements
- R1: Reset clears the shadowed ALU, LS1 and LS2 slots and the multi-cycle machine. Right after reset, fd_hold, alu_hold, alu_bubble, flush_fd and redirect are 0, and every fwd_sel field is 0, whatever Decode presents.
- R2: Each source has a 2-bit field in fwd_sel, with source k in bits [2k+1:2k]. The codes are: 0 = register bank, 1 = ALU slot, 2 = LS1 slot, 3 = LS2 slot. The youngest matching slot with a valid destination wins. An invalid source gives 0.
- R3: If Decode reads the destination of a word load (dec_ld_kind = 1) in ALU, fd_hold and alu_bubble are 1 for exactly one cycle. The bubble writes no register, and the consumer issues the next cycle with code 2. A consumer two slots behind a word load does not stall.
- R4: A consumer directly behind a byte or halfword load (dec_ld_kind = 2) stalls for two cycles. A consumer two slots behind one stalls for one cycle. In both cases it then issues with code 3.
- R5: A producer that is not a load (dec_ld_kind = 0) never causes a stall at any distance. Its results are forwarded with the codes of R2.
- R6: When alu_br_taken is 1 and the multi-cycle machine is idle, flush_fd, redirect and alu_bubble are 1 and fd_hold is 0 in that cycle. This holds even if a load interlock would otherwise stall Decode.
- R7: An instruction issued with dec_alu_cycles = C > 1 makes fd_hold and alu_hold 1, with alu_bubble 0, for the C-1 cycles after it enters ALU. A value of 0 or 1 causes no hold.
- R8: While alu_hold is 1, alu_br_taken is ignored, so flush_fd and redirect stay 0.
- R9: With dec_valid at 0 and the multi-cycle machine idle, fd_hold and alu_bubble are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_src_vld | input | NSRC (3) | Valid bit per source operand |
| dec_src_idx | input | NSRC*REG_W (12) | Source indices, source k at [4k+3:4k] |
| dec_dst_vld | input | 1 | Decode instruction writes a register |
| dec_dst_idx | input | REG_W (4) | Destination index |
| dec_ld_kind | input | 2 | 0 none, 1 word load, 2 byte/halfword load |
| dec_alu_cycles | input | CNT_W (4) | ALU cycles the instruction needs |
| alu_br_taken | input | 1 | Branch in ALU resolved taken |
| fd_hold | output | 1 | Fetch and Decode keep their contents |
| alu_hold | output | 1 | ALU keeps its instruction; LS1 receives a bubble |
| alu_bubble | output | 1 | ALU loads a no-op instead of Decode |
| flush_fd | output | 1 | Fetch and Decode slots are discarded |
| redirect | output | 1 | Fetch restarts at the branch target |
| fwd_sel | output | 2*NSRC (6) | Forwarding code per source, see R2 |

## Verification
Two functions can meet in one cycle, and the bench provokes both meetings. In the first, a branch in ALU is taken while the instruction in Decode reads a byte load sitting in LS1. The judgement is that flush wins: the bench expects flush_fd, redirect and alu_bubble with fd_hold low, and the forwarding field still reports code 2. In the second, a taken branch indication arrives during a multi-cycle hold. The judgement is that the hold wins and no flush appears. The bench's cycle table also sets stalls behind word and narrow loads against the forwarding codes that must follow them.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    parameter int REG_W = 4;
    parameter int NSRC  = 3;
    parameter int CNT_W = 4;

    typedef enum logic [1:0] {
        LD_NONE   = 2'd0,
        LD_WORD   = 2'd1,
        LD_NARROW = 2'd2
    } ld_kind_e;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_ALU = 2'd1,
        FWD_LS1 = 2'd2,
        FWD_LS2 = 2'd3
    } fwd_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_ISSUE,
        ACT_STALL,
        ACT_FLUSH,
        ACT_BUSY
    } act_e;

    typedef enum logic {
        MC_IDLE,
        MC_BUSY
    } mc_state_e;

    typedef struct packed {
        logic             vld;
        logic [REG_W-1:0] dst;
        ld_kind_e         ld;
    } slot_t;

endpackage

// File: rtl/ilk_src_match.sv
module ilk_src_match
    import ilk_pkg::*;
(
    input  logic             src_vld,
    input  logic [REG_W-1:0] src_idx,
    input  slot_t            slot_alu,
    input  slot_t            slot_ls1,
    input  slot_t            slot_ls2,
    output fwd_e             fwd,
    output logic             need_stall
);

    logic hit_alu;
    logic hit_ls1;
    logic hit_ls2;

    always_comb begin
        hit_alu = src_vld && slot_alu.vld && (slot_alu.dst == src_idx);
        hit_ls1 = src_vld && slot_ls1.vld && (slot_ls1.dst == src_idx);
        hit_ls2 = src_vld && slot_ls2.vld && (slot_ls2.dst == src_idx);
    end

    // youngest producer wins
    always_comb begin
        if (hit_alu)      fwd = FWD_ALU;
        else if (hit_ls1) fwd = FWD_LS1;
        else if (hit_ls2) fwd = FWD_LS2;
        else              fwd = FWD_RF;
    end

    // any load one slot ahead is late; a narrow load two slots ahead is late too
    always_comb begin
        need_stall = 1'b0;
        if (hit_alu) begin
            need_stall = (slot_alu.ld != LD_NONE);
        end else if (hit_ls1) begin
            need_stall = (slot_ls1.ld == LD_NARROW);
        end
    end

endmodule

// File: rtl/ilk_shadow_pipe.sv
module ilk_shadow_pipe
    import ilk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  alu_freeze,
    input  logic  issue,
    input  slot_t issue_slot,
    output slot_t slot_alu,
    output slot_t slot_ls1,
    output slot_t slot_ls2
);

    localparam slot_t EMPTY = '{vld: 1'b0, dst: '0, ld: LD_NONE};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_alu <= EMPTY;
            slot_ls1 <= EMPTY;
            slot_ls2 <= EMPTY;
        end else if (alu_freeze) begin
            slot_ls2 <= slot_ls1;
            slot_ls1 <= EMPTY;
        end else begin
            slot_ls2 <= slot_ls1;
            slot_ls1 <= slot_alu;
            slot_alu <= issue ? issue_slot : EMPTY;
        end
    end

endmodule

// File: rtl/ilk_mc_fsm.sv
module ilk_mc_fsm
    import ilk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cycles,
    output logic             busy
);

    mc_state_e        state_q;
    mc_state_e        state_d;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] left_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MC_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            MC_IDLE: begin
                if (start && (cycles > CNT_W'(1))) begin
                    state_d = MC_BUSY;
                    left_d  = cycles - CNT_W'(1);
                end
            end
            MC_BUSY: begin
                if (left_q <= CNT_W'(1)) begin
                    state_d = MC_IDLE;
                    left_d  = '0;
                end else begin
                    left_d  = left_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = MC_IDLE;
                left_d  = '0;
            end
        endcase
    end

    assign busy = (state_q == MC_BUSY);

endmodule

// File: rtl/ilk_ctrl.sv
module ilk_ctrl
    import ilk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dec_valid,
    input  logic [NSRC-1:0]       dec_src_vld,
    input  logic [NSRC*REG_W-1:0] dec_src_idx,
    input  logic                  dec_dst_vld,
    input  logic [REG_W-1:0]      dec_dst_idx,
    input  logic [1:0]            dec_ld_kind,
    input  logic [CNT_W-1:0]      dec_alu_cycles,
    input  logic                  alu_br_taken,
    output logic                  fd_hold,
    output logic                  alu_hold,
    output logic                  alu_bubble,
    output logic                  flush_fd,
    output logic                  redirect,
    output logic [2*NSRC-1:0]     fwd_sel
);

    slot_t           slot_alu;
    slot_t           slot_ls1;
    slot_t           slot_ls2;
    slot_t           dec_slot;
    logic [NSRC-1:0] src_stall;
    logic            busy;
    logic            stall_req;
    logic            flush_req;
    logic            issue;
    act_e            act;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        fwd_e f;
        ilk_src_match u_match (
            .src_vld    (dec_src_vld[k]),
            .src_idx    (dec_src_idx[k*REG_W +: REG_W]),
            .slot_alu   (slot_alu),
            .slot_ls1   (slot_ls1),
            .slot_ls2   (slot_ls2),
            .fwd        (f),
            .need_stall (src_stall[k])
        );
        assign fwd_sel[2*k +: 2] = f;
    end

    always_comb begin
        dec_slot.vld = dec_dst_vld;
        dec_slot.dst = dec_dst_idx;
        dec_slot.ld  = ld_kind_e'(dec_ld_kind);
    end

    always_comb begin
        stall_req = dec_valid && (|src_stall);
        flush_req = alu_br_taken && !busy;
        if (busy)            act = ACT_BUSY;
        else if (flush_req)  act = ACT_FLUSH;
        else if (!dec_valid) act = ACT_IDLE;
        else if (stall_req)  act = ACT_STALL;
        else                 act = ACT_ISSUE;
    end

    always_comb begin
        fd_hold    = 1'b0;
        alu_hold   = 1'b0;
        alu_bubble = 1'b0;
        flush_fd   = 1'b0;
        redirect   = 1'b0;
        issue      = 1'b0;
        unique case (act)
            ACT_IDLE:  ;
            ACT_ISSUE: issue = 1'b1;
            ACT_STALL: begin
                fd_hold    = 1'b1;
                alu_bubble = 1'b1;
            end
            ACT_FLUSH: begin
                flush_fd   = 1'b1;
                redirect   = 1'b1;
                alu_bubble = 1'b1;
            end
            ACT_BUSY: begin
                fd_hold  = 1'b1;
                alu_hold = 1'b1;
            end
            default: ;
        endcase
    end

    ilk_shadow_pipe u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .alu_freeze (busy),
        .issue      (issue),
        .issue_slot (dec_slot),
        .slot_alu   (slot_alu),
        .slot_ls1   (slot_ls1),
        .slot_ls2   (slot_ls2)
    );

    ilk_mc_fsm u_mc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (issue),
        .cycles (dec_alu_cycles),
        .busy   (busy)
    );

endmodule

// File: rtl/ilk_ctrl_chk.sv
module ilk_ctrl_chk
    import ilk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic [NSRC-1:0]   dec_src_vld,
    input logic              alu_br_taken,
    input logic              fd_hold,
    input logic              alu_hold,
    input logic              alu_bubble,
    input logic              flush_fd,
    input logic              redirect,
    input logic [2*NSRC-1:0] fwd_sel
);

    // R3
    stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_hold && !alu_hold) |-> alu_bubble);

    // R6
    flush_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fd |-> (redirect && alu_bubble && !fd_hold));

    // R7
    busy_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_hold |-> (fd_hold && !alu_bubble));

    // R8
    busy_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_hold && alu_br_taken) |-> (!flush_fd && !redirect));

    // R9
    idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid && !alu_hold && !alu_br_taken) |-> (!fd_hold && !alu_bubble));

    // R2
    for (genvar k = 0; k < NSRC; k++) begin : g_fwd
        invalid_src_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dec_src_vld[k] |-> (fwd_sel[2*k +: 2] == 2'd0));
    end

endmodule

bind ilk_ctrl ilk_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_valid    (dec_valid),
    .dec_src_vld  (dec_src_vld),
    .alu_br_taken (alu_br_taken),
    .fd_hold      (fd_hold),
    .alu_hold     (alu_hold),
    .alu_bubble   (alu_bubble),
    .flush_fd     (flush_fd),
    .redirect     (redirect),
    .fwd_sel      (fwd_sel)
);

// File: tb/ilk_ctrl_tb.sv
module ilk_ctrl_tb;
    import ilk_pkg::*;

    typedef struct packed {
        logic       dv;
        logic       s0v; logic [3:0] s0;
        logic       s1v; logic [3:0] s1;
        logic       s2v; logic [3:0] s2;
        logic       ddv; logic [3:0] dd;
        logic [1:0] ld;
        logic [3:0] cyc;
        logic       br;
        logic       eh; logic eb; logic ea; logic ef;
        logic [1:0] f0; logic [1:0] f1; logic [1:0] f2;
        logic [3:0] req;
    } row_t;

    function automatic row_t mk(
        input logic dv, input logic s0v, input logic [3:0] s0,
        input logic s1v, input logic [3:0] s1, input logic s2v, input logic [3:0] s2,
        input logic ddv, input logic [3:0] dd, input logic [1:0] ld, input logic [3:0] cyc,
        input logic br, input logic eh, input logic eb, input logic ea, input logic ef,
        input logic [1:0] f0, input logic [1:0] f1, input logic [1:0] f2, input logic [3:0] req);
        row_t r;
        r = '{dv, s0v, s0, s1v, s1, s2v, s2, ddv, dd, ld, cyc, br,
              eh, eb, ea, ef, f0, f1, f2, req};
        return r;
    endfunction

    localparam int NROWS = 26;
    //                   dv s0v s0 s1v s1 s2v s2 ddv dd ld cyc br  eh eb ea ef  f0 f1 f2 req
    localparam row_t TBL [NROWS] = '{
        mk(1, 1,2,  0,0,  0,0,  1,1,  1,1, 0, 0,0,0,0, 0,0,0, 3),  // R3 word load r1
        mk(1, 1,0,  1,1,  0,0,  1,0,  0,1, 0, 1,1,0,0, 0,1,0, 3),  // R3 stall
        mk(1, 1,0,  1,1,  0,0,  1,0,  0,1, 0, 0,0,0,0, 0,2,0, 3),  // R3 issue code 2
        mk(1, 1,0,  0,0,  0,0,  1,3,  2,1, 0, 0,0,0,0, 1,0,0, 5),  // R5 narrow load r3
        mk(1, 0,0,  0,0,  1,3,  1,4,  0,1, 0, 1,1,0,0, 0,0,1, 4),  // R4 stall 1
        mk(1, 0,0,  0,0,  1,3,  1,4,  0,1, 0, 1,1,0,0, 0,0,2, 4),  // R4 stall 2
        mk(1, 0,0,  0,0,  1,3,  1,4,  0,1, 0, 0,0,0,0, 0,0,3, 4),  // R4 issue code 3
        mk(1, 1,4,  0,0,  0,0,  1,5,  2,1, 0, 0,0,0,0, 1,0,0, 5),  // R5 narrow load r5
        mk(1, 1,7,  0,0,  0,0,  1,6,  0,1, 0, 0,0,0,0, 0,0,0, 2),  // R2 no match
        mk(1, 1,5,  1,4,  0,0,  1,8,  0,1, 0, 1,1,0,0, 2,3,0, 4),  // R4 two behind
        mk(1, 1,5,  1,4,  0,0,  1,8,  0,1, 0, 0,0,0,0, 3,0,0, 4),  // R4 issue
        mk(1, 1,8,  1,6,  0,0,  1,9,  0,3, 0, 0,0,0,0, 1,3,0, 2),  // R2 mul r9 C=3
        mk(1, 1,9,  0,0,  0,0,  1,10, 0,1, 0, 1,0,1,0, 1,0,0, 7),  // R7 busy 1
        mk(1, 1,9,  0,0,  0,0,  1,10, 0,1, 0, 1,0,1,0, 1,0,0, 7),  // R7 busy 2
        mk(1, 1,9,  0,0,  0,0,  1,10, 0,1, 0, 0,0,0,0, 1,0,0, 5),  // R5 no stall on mul
        mk(1, 1,10, 0,0,  0,0,  1,11, 2,1, 0, 0,0,0,0, 1,0,0, 5),  // R5 narrow load r11
        mk(1, 0,0,  0,0,  0,0,  0,0,  0,1, 0, 0,0,0,0, 0,0,0, 6),  // R6 branch issues
        mk(1, 1,11, 0,0,  0,0,  1,1,  0,1, 1, 0,1,0,1, 2,0,0, 6),  // R6 flush beats stall
        mk(0, 0,0,  0,0,  0,0,  0,0,  0,1, 0, 0,0,0,0, 0,0,0, 9),  // R9 empty decode
        mk(1, 1,11, 0,0,  0,0,  1,12, 0,1, 0, 0,0,0,0, 0,0,0, 6),  // R6 target, load gone
        mk(1, 0,0,  0,0,  0,0,  1,2,  0,2, 0, 0,0,0,0, 0,0,0, 7),  // R7 mul C=2
        mk(1, 0,0,  0,0,  0,0,  0,0,  0,1, 1, 1,0,1,0, 0,0,0, 8),  // R8 branch ignored
        mk(1, 0,0,  0,0,  0,0,  0,0,  0,1, 0, 0,0,0,0, 0,0,0, 7),  // R7 released
        mk(1, 1,0,  0,0,  0,0,  1,12, 1,1, 0, 0,0,0,0, 0,0,0, 3),  // R3 word load r12
        mk(1, 0,0,  0,0,  0,0,  1,13, 0,0, 0, 0,0,0,0, 0,0,0, 7),  // R7 C=0 no hold
        mk(1, 1,12, 0,0,  0,0,  1,14, 0,1, 0, 0,0,0,0, 2,0,0, 3)   // R3 two behind
    };

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  dec_valid;
    logic [NSRC-1:0]       dec_src_vld;
    logic [NSRC*REG_W-1:0] dec_src_idx;
    logic                  dec_dst_vld;
    logic [REG_W-1:0]      dec_dst_idx;
    logic [1:0]            dec_ld_kind;
    logic [CNT_W-1:0]      dec_alu_cycles;
    logic                  alu_br_taken;
    logic                  fd_hold, alu_hold, alu_bubble, flush_fd, redirect;
    logic [2*NSRC-1:0]     fwd_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ilk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src_vld(dec_src_vld),
        .dec_src_idx(dec_src_idx), .dec_dst_vld(dec_dst_vld), .dec_dst_idx(dec_dst_idx),
        .dec_ld_kind(dec_ld_kind), .dec_alu_cycles(dec_alu_cycles),
        .alu_br_taken(alu_br_taken), .fd_hold(fd_hold), .alu_hold(alu_hold),
        .alu_bubble(alu_bubble), .flush_fd(flush_fd), .redirect(redirect),
        .fwd_sel(fwd_sel)
    );

    task automatic chk(input string what, input int req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic drive(input row_t r);
        dec_valid      = r.dv;
        dec_src_vld    = {r.s2v, r.s1v, r.s0v};
        dec_src_idx    = {r.s2, r.s1, r.s0};
        dec_dst_vld    = r.ddv;
        dec_dst_idx    = r.dd;
        dec_ld_kind    = r.ld;
        dec_alu_cycles = r.cyc;
        alu_br_taken   = r.br;
    endtask

    task automatic check_row(input row_t r, input int i);
        string tag;
        tag = $sformatf("row %0d", i);
        chk({tag, " fd_hold"},    int'(r.req), int'(fd_hold),    int'(r.eh));
        chk({tag, " alu_bubble"}, int'(r.req), int'(alu_bubble), int'(r.eb));
        chk({tag, " alu_hold"},   int'(r.req), int'(alu_hold),   int'(r.ea));
        chk({tag, " flush_fd"},   int'(r.req), int'(flush_fd),   int'(r.ef));
        chk({tag, " redirect"},   int'(r.req), int'(redirect),   int'(r.ef));
        chk({tag, " fwd0"},       int'(r.req), int'(fwd_sel[1:0]), int'(r.f0));
        chk({tag, " fwd1"},       int'(r.req), int'(fwd_sel[3:2]), int'(r.f1));
        chk({tag, " fwd2"},       int'(r.req), int'(fwd_sel[5:4]), int'(r.f2));
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(mk(0, 0,0, 0,0, 0,0, 0,0, 0,0, 0, 0,0,0,0, 0,0,0, 1));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, decode reads r1 which nothing holds
        drive(mk(1, 1,1, 1,2, 0,0, 0,0, 0,1, 0, 0,0,0,0, 0,0,0, 1));
        @(negedge clk);
        check_row(mk(1, 1,1, 1,2, 0,0, 0,0, 0,1, 0, 0,0,0,0, 0,0,0, 1), -1);
        drive(mk(0, 0,0, 0,0, 0,0, 0,0, 0,1, 0, 0,0,0,0, 0,0,0, 1));

        for (int i = 0; i < NROWS; i++) begin
            @(posedge clk);
            #1 drive(TBL[i]);
            @(negedge clk);
            check_row(TBL[i], i);
        end

        // R1: reset in the middle of a multi-cycle hold
        @(posedge clk);
        #1 drive(mk(1, 0,0, 0,0, 0,0, 1,7, 0,6, 0, 0,0,0,0, 0,0,0, 1));
        @(posedge clk);
        #1 drive(mk(1, 1,7, 0,0, 0,0, 0,0, 0,1, 0, 1,0,1,0, 1,0,0, 7));
        @(negedge clk);
        chk("mid hold fd_hold", 7, int'(fd_hold), 1);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("post reset fd_hold",  1, int'(fd_hold), 0);
        chk("post reset alu_hold", 1, int'(alu_hold), 0);
        chk("post reset fwd0",     1, int'(fwd_sel[1:0]), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule